// File: doc/BRIEF.md
# CPU Debug Control Register Unit

This unit sits beside a pipelined CPU and gives an external debug host control over it through a small memory-mapped command bus. The host sends commands on a valid/ready stream that carries a write flag, an 8-bit address and a 32-bit data word. Every accepted command produces a response one cycle later.

The unit holds four flags. One holds the CPU in reset, one halts it, one records that the halt came from a breakpoint, and one enables single-step. A status word shows these flags together with the pipeline-busy input. A second address returns the last value the CPU wrote into its register file. Writing that address hands a 32-bit instruction word to the pipeline, and the command stalls until the CPU takes it.

The unit runs in its own clock domain with its own reset. The reset flag it drives toward the CPU therefore never clears the unit's own state.

Top module: `dbg_ctrl_unit`

## Requirements
- R1: After reset, `cpu_reset`, `cpu_halt`, `rsp_valid`, the breakpoint flag and the step flag are all 0.
- R2: `rsp_valid` is 1 in exactly the cycle after a command is accepted (`cmd_valid` and `cmd_ready` both 1), and 0 otherwise. An accepted write returns `rsp_rdata` = 0.
- R3: Reading address 0x00 returns the status word: bit 0 reset flag, bit 1 halt flag, bit 2 `cpu_busy` sampled when the command is accepted, bit 3 breakpoint flag, bit 4 step flag. All other bits are 0.
- R4: A write to 0x00 with bit 16 set sets the reset flag, and bit 24 clears it. When both bits are set, clear wins. The reset flag drives `cpu_reset` and leaves the unit's other state unchanged.
- R5: A write to 0x00 with bit 17 set sets the halt flag. Bit 25 clears both the halt flag and the breakpoint flag. Bit 25 wins over every source that would set these flags in the same cycle. The halt flag drives `cpu_halt`.
- R6: Every write to 0x00 loads the step flag from data bit 4.
- R7: A `cpu_brk` pulse sets both the halt flag and the breakpoint flag, with effect from the next cycle.
- R8: While the step flag is 1 and the CPU is not halted, a `cpu_issue` pulse sets the halt flag. Clearing the halt with the step flag set therefore lets exactly one instruction through. With the step flag at 0, `cpu_issue` has no effect.
- R9: Reading address 0x04 returns the last `cpu_rf_wdata` captured while `cpu_rf_we` was 1.
- R10: A write to 0x04 drives `inj_valid` = 1 and `inj_instr` = the write data. `cmd_ready` stays 0 until `inj_ready` is 1, and the write is accepted in that cycle.
- R11: A read of any address other than 0x00 and 0x04 returns 0. A write to such an address changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug-domain clock |
| rst_n | input | 1 | Debug-domain reset, active low, asynchronous |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after acceptance) |
| rsp_rdata | output | 32 | Response data |
| cpu_busy | input | 1 | Pipeline still has instructions in flight |
| cpu_brk | input | 1 | Breakpoint reached (pulse) |
| cpu_issue | input | 1 | One instruction issued (pulse) |
| cpu_rf_we | input | 1 | Register-file write strobe |
| cpu_rf_wdata | input | 32 | Register-file write value |
| cpu_reset | output | 1 | Hold the CPU in reset |
| cpu_halt | output | 1 | Stop the CPU from issuing |
| inj_valid | output | 1 | Injected instruction present |
| inj_instr | output | 32 | Injected instruction word |
| inj_ready | input | 1 | CPU takes the injected instruction |

## Verification
The hardest situations to reach come from events that coincide in one cycle. One is a breakpoint pulse arriving in the same cycle as a resume write. The other is a single step, which needs the step flag set, a resume write, and then an issue pulse in that order. The bench builds both with directed sequences. It drives `cpu_brk` together with the write command, then steps with the flag set and again with it clear. Random traffic also mixes set and clear bits freely, so that both-bits-at-once writes occur often. Injection is driven with a random number of stall cycles before `inj_ready` is raised.

// File: rtl/dbg_ctrl_unit.sv
module dbg_ctrl_unit #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] STATUS_ADDR = 'h00,
  parameter logic [AW-1:0] INJECT_ADDR = 'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          cpu_busy,
  input  logic          cpu_brk,
  input  logic          cpu_issue,
  input  logic          cpu_rf_we,
  input  logic [DW-1:0] cpu_rf_wdata,
  output logic          cpu_reset,
  output logic          cpu_halt,
  output logic          inj_valid,
  output logic [DW-1:0] inj_instr,
  input  logic          inj_ready
);
  localparam int B_STEP   = 4;
  localparam int B_SETRST = 16;
  localparam int B_SETHLT = 17;
  localparam int B_CLRRST = 24;
  localparam int B_CLRHLT = 25;

  logic          reset_q, halt_q, brk_q, step_q;
  logic [DW-1:0] rf_q;
  logic          inj_req, accept, wr_stat, halt_set, halt_clr;
  logic [DW-1:0] rd_word;

  assign inj_req   = cmd_valid & cmd_write & (cmd_addr == INJECT_ADDR);
  assign cmd_ready = ~inj_req | inj_ready;
  assign inj_valid = inj_req;
  assign inj_instr = cmd_wdata;
  assign accept    = cmd_valid & cmd_ready;
  assign wr_stat   = accept & cmd_write & (cmd_addr == STATUS_ADDR);

  assign halt_clr = wr_stat & cmd_wdata[B_CLRHLT];
  assign halt_set = (wr_stat & cmd_wdata[B_SETHLT]) | cpu_brk
                  | (step_q & ~halt_q & cpu_issue);

  assign cpu_reset = reset_q;
  assign cpu_halt  = halt_q;

  always_comb begin
    rd_word = '0;
    if (cmd_addr == STATUS_ADDR)
      rd_word[4:0] = {step_q, brk_q, cpu_busy, halt_q, reset_q};
    else if (cmd_addr == INJECT_ADDR)
      rd_word = rf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_q <= 1'b0;
      halt_q  <= 1'b0;
      brk_q   <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      if (wr_stat & cmd_wdata[B_CLRRST])      reset_q <= 1'b0;
      else if (wr_stat & cmd_wdata[B_SETRST]) reset_q <= 1'b1;
      if (halt_clr)      halt_q <= 1'b0;
      else if (halt_set) halt_q <= 1'b1;
      if (halt_clr)     brk_q <= 1'b0;
      else if (cpu_brk) brk_q <= 1'b1;
      if (wr_stat) step_q <= cmd_wdata[B_STEP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rf_q <= '0;
    else if (cpu_rf_we) rf_q <= cpu_rf_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) rsp_rdata <= cmd_write ? '0 : rd_word;
    end
  end
endmodule

// File: rtl/dbg_ctrl_unit_chk.sv
module dbg_ctrl_unit_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] STATUS_ADDR = 'h00,
  parameter logic [AW-1:0] INJECT_ADDR = 'h04
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_write,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] cmd_wdata,
  input logic          rsp_valid,
  input logic          cpu_brk,
  input logic          cpu_issue,
  input logic          cpu_halt,
  input logic          cpu_reset,
  input logic          inj_valid,
  input logic          inj_ready,
  input logic [DW-1:0] inj_instr,
  input logic          step_q
);
  logic stat_wr;
  assign stat_wr = cmd_valid && cmd_ready && cmd_write && cmd_addr == STATUS_ADDR;

  p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);
  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !rsp_valid);
  p_rst_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && cmd_wdata[24]) |=> !cpu_reset);
  p_halt_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && cmd_wdata[25]) |=> !cpu_halt);
  p_brk_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_brk && !(stat_wr && cmd_wdata[25])) |=> cpu_halt);
  p_step_rehalt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && !cpu_halt && cpu_issue && !(stat_wr && cmd_wdata[25])) |=> cpu_halt);
  p_inj_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_addr == INJECT_ADDR && !inj_ready) |-> !cmd_ready);
  p_inj_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> (inj_instr == cmd_wdata && cmd_valid));
endmodule

bind dbg_ctrl_unit dbg_ctrl_unit_chk #(
  .AW(AW), .DW(DW), .STATUS_ADDR(STATUS_ADDR), .INJECT_ADDR(INJECT_ADDR)
) u_chk (.*);

// File: tb/sim_dbg_ctrl_unit.sv
module sim_dbg_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_write = 0;
  logic [7:0]  cmd_addr = 0;
  logic [31:0] cmd_wdata = 0;
  logic        cmd_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cpu_busy = 0, cpu_brk = 0, cpu_issue = 0, cpu_rf_we = 0;
  logic [31:0] cpu_rf_wdata = 0;
  logic        cpu_reset, cpu_halt, inj_valid;
  logic [31:0] inj_instr;
  logic        inj_ready = 0;

  int checks = 0, fails = 0, cycles = 0;
  logic m_rst = 0, m_halt = 0, m_brk = 0, m_step = 0;
  logic [31:0] m_rf = 0;

  always #5 clk = ~clk;

  dbg_ctrl_unit u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(logic busy);
    return {27'b0, m_step, m_brk, busy, m_halt, m_rst};
  endfunction

  function automatic void model_wr0(logic [31:0] d, logic brk);
    if (d[24]) m_rst = 0; else if (d[16]) m_rst = 1;
    if (d[25]) begin m_halt = 0; m_brk = 0; end
    else begin
      if (d[17] || brk) m_halt = 1;
      if (brk) m_brk = 1;
    end
    m_step = d[4];
  endfunction

  task automatic cmd(logic wr, logic [7:0] a, logic [31:0] d, logic brk, logic busy,
                     output logic [31:0] rd);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    cpu_brk = brk; cpu_busy = busy;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0; cpu_brk = 0; cpu_busy = 0;
    chk("R2 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
    @(posedge clk);
    @(negedge clk);
    chk("R2 rsp_valid low", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic check_status(string req);
    logic [31:0] r;
    logic b = 1'($urandom % 2);
    cmd(0, 8'h00, 0, 0, b, r);
    chk(req, r, exp_status(b));
    chk({req, " halt pin"}, {31'b0, cpu_halt}, {31'b0, m_halt});
    chk({req, " reset pin"}, {31'b0, cpu_reset}, {31'b0, m_rst});
  endtask

  task automatic pulse_issue();
    cpu_issue = 1;
    @(posedge clk);
    @(negedge clk);
    cpu_issue = 0;
    if (m_step && !m_halt) m_halt = 1;
  endtask

  task automatic rf_write(logic [31:0] v);
    cpu_rf_we = 1; cpu_rf_wdata = v;
    @(posedge clk);
    @(negedge clk);
    cpu_rf_we = 0;
    m_rf = v;
  endtask

  task automatic inject(logic [31:0] w, int stall);
    logic [31:0] r;
    cmd_valid = 1; cmd_write = 1; cmd_addr = 8'h04; cmd_wdata = w; inj_ready = 0;
    for (int i = 0; i < stall; i++) begin
      #1;
      chk("R10 stall ready", {31'b0, cmd_ready}, 32'd0);
      chk("R10 inj_valid", {31'b0, inj_valid}, 32'd1);
      chk("R10 inj_instr", inj_instr, w);
      @(negedge clk);
      chk("R2 no rsp during stall", {31'b0, rsp_valid}, 32'd0);
    end
    inj_ready = 1;
    #1;
    chk("R10 ready with inj_ready", {31'b0, cmd_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0; inj_ready = 0;
    chk("R10 accepted", {31'b0, rsp_valid}, 32'd1);
    chk("R2 write rsp zero", rsp_rdata, 32'd0);
    #1;
    chk("R10 inj_valid drop", {31'b0, inj_valid}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r, d;
    void'($urandom(32'h1d2b));
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R1 cpu_halt", {31'b0, cpu_halt}, 0);
    chk("R1 cpu_reset", {31'b0, cpu_reset}, 0);
    rst_n = 1;
    @(negedge clk);
    check_status("R1 status after reset");

    // R4: set and clear in one write -> clear wins; reset flag leaves unit alive
    cmd(1, 8'h00, 32'h0001_0000, 0, 0, r); model_wr0(32'h0001_0000, 0);
    chk("R2 write rsp zero", r, 0);
    check_status("R4 reset set");
    rf_write(32'hCAFE_0001);
    cmd(0, 8'h04, 0, 0, 0, r);
    chk("R4 unit alive under cpu_reset R9", r, 32'hCAFE_0001);
    cmd(1, 8'h00, 32'h0101_0000, 0, 0, r); model_wr0(32'h0101_0000, 0);
    check_status("R4 clear wins");

    // R5: halt set, then set+clear
    cmd(1, 8'h00, 32'h0002_0000, 0, 0, r); model_wr0(32'h0002_0000, 0);
    check_status("R5 halt set");
    cmd(1, 8'h00, 32'h0202_0000, 0, 0, r); model_wr0(32'h0202_0000, 0);
    check_status("R5 clear wins");

    // R7: breakpoint sets halt and break
    cpu_brk = 1; @(posedge clk); @(negedge clk); cpu_brk = 0;
    m_halt = 1; m_brk = 1;
    check_status("R7 brk");
    // R5: clear together with breakpoint -> clear wins
    cmd(1, 8'h00, 32'h0200_0000, 1, 0, r); model_wr0(32'h0200_0000, 1);
    check_status("R5 clear beats brk");

    // R6 / R8: single step
    cmd(1, 8'h00, 32'h0002_0010, 0, 0, r); model_wr0(32'h0002_0010, 0);
    check_status("R6 step loaded");
    cmd(1, 8'h00, 32'h0200_0010, 0, 0, r); model_wr0(32'h0200_0010, 0);
    check_status("R8 resumed for one");
    pulse_issue();
    check_status("R8 rehalt after issue");
    cmd(1, 8'h00, 32'h0200_0000, 0, 0, r); model_wr0(32'h0200_0000, 0);
    pulse_issue();
    check_status("R8 no step no halt");

    // R11: unmapped
    cmd(1, 8'h08, 32'hFFFF_FFFF, 0, 0, r);
    check_status("R11 unmapped write ignored");
    cmd(0, 8'h80, 0, 0, 1, r);
    chk("R11 unmapped read zero", r, 0);

    // R10: injection
    inject(32'h0010_0073, 0);
    inject(32'h1234_5678, 3);
    check_status("R10 inject leaves flags");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 8;
      case (op)
        0, 1: begin
          d = {$urandom} & 32'h0303_0010;
          d[4] = 1'($urandom % 2);
          cmd(1, 8'h00, d, 0, 0, r); model_wr0(d, 0);
          chk("R2 write rsp zero", r, 0);
        end
        2: begin
          cpu_brk = 1; @(posedge clk); @(negedge clk); cpu_brk = 0;
          m_halt = 1; m_brk = 1;
        end
        3: pulse_issue();
        4: rf_write($urandom);
        5: begin cmd(0, 8'h04, 0, 0, 0, r); chk("R9 rf readback", r, m_rf); end
        6: inject($urandom, $urandom % 4);
        default: begin
          cmd(0, 8'h01 + 8'($urandom % 3), 0, 0, 1, r);
          chk("R11 unmapped read zero", r, 0);
        end
      endcase
      check_status("R3 status random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule